// File: doc/BRIEF.md
# Hub Port Status Light Controller

This block drives a two-colour status light, with one green and one amber enable, for each downstream port of a hub. Each port is in one of two modes. In automatic mode the colour comes from the port's live status: power, enabled, transmit, transmitR and over-current. In manual mode the host sets the colour to amber, green or off, and the port's status does not change it. The host makes any blinking by switching between manual colours. The hardware has no blink timer.

Commands arrive one per cycle on a small request bus. A command is a set or a clear, names either the indicator feature or the port-power feature, gives a target port index, and carries an 8-bit selector. The decoded command updates the mode of the target port on the next clock edge. The light enables follow combinationally from the stored mode and the current status.

Top module: `port_light_ctrl`

## Requirements
- R1: After reset every port is in automatic mode. With all status inputs at 0, both enables of every port are 0.
- R2: A set command on the indicator feature (cmd_feat_i = 0) with selector 0 puts the target port in automatic mode.
- R3: A clear command (cmd_set_i = 0) on the indicator feature puts the target port in automatic mode, whatever the selector.
- R4: A set command on the indicator feature chooses a manual colour from the selector: 1 gives amber, 2 gives green, 3 gives off. In manual mode the status inputs have no effect on the enables.
- R5: A set command on the indicator feature with a selector from 4 to 255 leaves the mode of the target port unchanged.
- R6: In automatic mode, an over-current status of 1 turns amber on and green off.
- R7: In automatic mode with no over-current, green is on when the port is powered and at least one of enabled, transmit or transmitR is 1. Otherwise both enables are 0.
- R8: A set command on the port-power feature (cmd_feat_i = 1) puts the target port in automatic mode. A clear command on the port-power feature leaves the mode unchanged.
- R9: A command changes only the port that cmd_port_i selects. The new mode shows at the enables from the clock edge that captures the command. An index at or above the port count changes no port.
- R10: The green and amber enables of a port are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_set_i | input | 1 | 1 = set feature, 0 = clear feature |
| cmd_feat_i | input | 1 | 0 = indicator feature, 1 = port-power feature |
| cmd_port_i | input | IDX_W | Index of the target port |
| cmd_sel_i | input | 8 | Indicator selector |
| port_pwr_i | input | NPORTS | Port powered, one bit per port |
| port_en_i | input | NPORTS | Port enabled |
| port_tx_i | input | NPORTS | Port in transmit state |
| port_txr_i | input | NPORTS | Port in transmitR state |
| port_oc_i | input | NPORTS | Port over-current |
| led_grn_o | output | NPORTS | Green enable per port |
| led_amb_o | output | NPORTS | Amber enable per port |

## Verification
The stored mode of each port is the only internal state. A wrong mode shows up at the enables in the first cycle after the command that caused it, but only if the status inputs tell the modes apart. For example, a port wrongly left in automatic mode looks the same as manual off while its status is idle. For that reason, every manual colour is checked with status inputs that would give a different automatic colour. Every return to automatic mode is checked with status that gives green or amber. Reserved selectors and commands aimed at other ports are checked by showing that a non-default manual colour stays in place.

// File: rtl/port_light_pkg.sv
package port_light_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO = 2'd0,
    MODE_AMB  = 2'd1,
    MODE_GRN  = 2'd2,
    MODE_OFF  = 2'd3
  } light_mode_e;

  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_AUTO = 3'd1,
    ACT_AMB  = 3'd2,
    ACT_GRN  = 3'd3,
    ACT_OFF  = 3'd4
  } light_act_e;

  localparam logic FEAT_IND = 1'b0;
  localparam logic FEAT_PWR = 1'b1;
endpackage

// File: rtl/port_light_dec.sv
module port_light_dec
  import port_light_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int IDX_W  = 2
) (
  input  logic              cmd_valid_i,
  input  logic              cmd_set_i,
  input  logic              cmd_feat_i,
  input  logic [IDX_W-1:0]  cmd_port_i,
  input  logic [7:0]        cmd_sel_i,
  output logic [NPORTS-1:0] hit_o,
  output light_act_e        act_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (!cmd_set_i) begin
      if (cmd_feat_i == FEAT_IND) act_o = ACT_AUTO;
    end else if (cmd_feat_i == FEAT_PWR) begin
      act_o = ACT_AUTO;
    end else begin
      unique case (cmd_sel_i)
        8'd0:    act_o = ACT_AUTO;
        8'd1:    act_o = ACT_AMB;
        8'd2:    act_o = ACT_GRN;
        8'd3:    act_o = ACT_OFF;
        default: act_o = ACT_NONE;  // reserved
      endcase
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_hit
    assign hit_o[g] = cmd_valid_i && (cmd_port_i == IDX_W'(g));
  end
endmodule

// File: rtl/port_light_cell.sv
module port_light_cell
  import port_light_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hit_i,
  input  light_act_e  act_i,
  input  logic        pwr_i,
  input  logic        en_i,
  input  logic        tx_i,
  input  logic        txr_i,
  input  logic        oc_i,
  output light_mode_e mode_o,
  output logic        grn_o,
  output logic        amb_o
);
  light_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_AUTO;
    end else if (hit_i) begin
      unique case (act_i)
        ACT_AUTO: mode_q <= MODE_AUTO;
        ACT_AMB:  mode_q <= MODE_AMB;
        ACT_GRN:  mode_q <= MODE_GRN;
        ACT_OFF:  mode_q <= MODE_OFF;
        default:  mode_q <= mode_q;
      endcase
    end
  end

  always_comb begin
    grn_o = 1'b0;
    amb_o = 1'b0;
    unique case (mode_q)
      MODE_AUTO: begin
        amb_o = oc_i;
        grn_o = !oc_i && pwr_i && (en_i || tx_i || txr_i);
      end
      MODE_AMB: amb_o = 1'b1;
      MODE_GRN: grn_o = 1'b1;
      default:  ;
    endcase
  end

  assign mode_o = mode_q;

  // R10
  excl_color_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grn_o && amb_o));

  // R6
  auto_oc_amb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_AUTO && oc_i) |-> (amb_o && !grn_o));

  // R4
  man_amb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_AMB) |-> (amb_o && !grn_o));

  // R3
  to_auto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && act_i == ACT_AUTO) |=> (mode_q == MODE_AUTO));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(mode_q));
endmodule

// File: rtl/port_light_ctrl.sv
module port_light_ctrl
  import port_light_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_set_i,
  input  logic              cmd_feat_i,
  input  logic [IDX_W-1:0]  cmd_port_i,
  input  logic [7:0]        cmd_sel_i,
  input  logic [NPORTS-1:0] port_pwr_i,
  input  logic [NPORTS-1:0] port_en_i,
  input  logic [NPORTS-1:0] port_tx_i,
  input  logic [NPORTS-1:0] port_txr_i,
  input  logic [NPORTS-1:0] port_oc_i,
  output logic [NPORTS-1:0] led_grn_o,
  output logic [NPORTS-1:0] led_amb_o
);
  logic [NPORTS-1:0] hit;
  light_act_e        act;
  light_mode_e       mode [NPORTS];

  port_light_dec #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_set_i   (cmd_set_i),
    .cmd_feat_i  (cmd_feat_i),
    .cmd_port_i  (cmd_port_i),
    .cmd_sel_i   (cmd_sel_i),
    .hit_o       (hit),
    .act_o       (act)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_light_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit[p]),
      .act_i  (act),
      .pwr_i  (port_pwr_i[p]),
      .en_i   (port_en_i[p]),
      .tx_i   (port_tx_i[p]),
      .txr_i  (port_txr_i[p]),
      .oc_i   (port_oc_i[p]),
      .mode_o (mode[p]),
      .grn_o  (led_grn_o[p]),
      .amb_o  (led_amb_o[p])
    );

    // R5
    rsv_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && cmd_set_i && cmd_feat_i == FEAT_IND && cmd_sel_i > 8'd3)
        |=> $stable(mode[p]));

    // R8
    pwr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && !cmd_set_i && cmd_feat_i == FEAT_PWR) |=> $stable(mode[p]));
  end

  // R9
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(hit));
endmodule

// File: tb/port_light_ctrl_tb.sv
module port_light_ctrl_tb_top;
  localparam int  NP    = 4;
  localparam time TCLK  = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cv = 1'b0, cs = 1'b0, cf = 1'b0;
  logic [1:0]    cp = '0;
  logic [7:0]    csel = '0;
  logic [NP-1:0] pwr = '0, en = '0, tx = '0, txr = '0, oc = '0;
  logic [NP-1:0] grn, amb;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  port_light_ctrl #(.NPORTS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv), .cmd_set_i(cs), .cmd_feat_i(cf),
    .cmd_port_i(cp), .cmd_sel_i(csel), .port_pwr_i(pwr), .port_en_i(en),
    .port_tx_i(tx), .port_txr_i(txr), .port_oc_i(oc),
    .led_grn_o(grn), .led_amb_o(amb)
  );

  task automatic chk(input int p, input logic eg, input logic ea, input string req);
    n_chk++;
    if (grn[p] !== eg || amb[p] !== ea) begin
      n_fail++;
      $display("FAIL %s port %0d: grn/amb=%b%b expected %b%b", req, p, grn[p], amb[p], eg, ea);
    end
  endtask

  task automatic cmd(input logic set, input logic feat, input int p, input logic [7:0] sel);
    @(negedge clk);
    cv = 1'b1; cs = set; cf = feat; cp = 2'(p); csel = sel;
    @(negedge clk);
    cv = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int p = 0; p < NP; p++) chk(p, 1'b0, 1'b0, "R1");
    pwr = '1; en[0] = 1'b1; settle();
    chk(0, 1'b1, 1'b0, "R1 auto after reset");
    en = '0; settle();
  endtask

  task automatic t_auto();
    pwr = '1;
    en[0] = 1'b1; settle(); chk(0, 1'b1, 1'b0, "R7 enabled");
    en[0] = 1'b0; tx[0] = 1'b1; settle(); chk(0, 1'b1, 1'b0, "R7 transmit");
    tx[0] = 1'b0; txr[0] = 1'b1; settle(); chk(0, 1'b1, 1'b0, "R7 transmitR");
    txr[0] = 1'b0; settle(); chk(0, 1'b0, 1'b0, "R7 idle off");
    en[0] = 1'b1; pwr[0] = 1'b0; settle(); chk(0, 1'b0, 1'b0, "R7 unpowered");
    pwr[0] = 1'b1; oc[0] = 1'b1; settle(); chk(0, 1'b0, 1'b1, "R6 oc over enabled");
    en[0] = 1'b0; settle(); chk(0, 1'b0, 1'b1, "R6 oc idle");
    oc[0] = 1'b0; settle(); chk(0, 1'b0, 1'b0, "R10 auto back off");
  endtask

  task automatic t_manual();
    en[1] = 1'b1;
    cmd(1'b1, 1'b0, 1, 8'd1); chk(1, 1'b0, 1'b1, "R4 manual amber");
    cmd(1'b1, 1'b0, 1, 8'd2); chk(1, 1'b1, 1'b0, "R4 manual green");
    oc[1] = 1'b1; settle(); chk(1, 1'b1, 1'b0, "R4 green ignores oc");
    cmd(1'b1, 1'b0, 1, 8'd3); chk(1, 1'b0, 1'b0, "R4 manual off with oc");
    oc[1] = 1'b0; settle(); chk(1, 1'b0, 1'b0, "R4 off ignores enabled");
  endtask

  task automatic t_reserved();
    cmd(1'b1, 1'b0, 1, 8'd1); chk(1, 1'b0, 1'b1, "R5 setup");
    cmd(1'b1, 1'b0, 1, 8'd4); chk(1, 1'b0, 1'b1, "R5 sel 4");
    cmd(1'b1, 1'b0, 1, 8'hFF); chk(1, 1'b0, 1'b1, "R5 sel FF");
    cmd(1'b1, 1'b0, 1, 8'h80); chk(1, 1'b0, 1'b1, "R5 sel 80");
  endtask

  task automatic t_to_auto();
    cmd(1'b1, 1'b0, 1, 8'd0); chk(1, 1'b1, 1'b0, "R2 sel 0 auto");
    cmd(1'b1, 1'b0, 1, 8'd3); chk(1, 1'b0, 1'b0, "R3 setup");
    cmd(1'b0, 1'b0, 1, 8'h55); chk(1, 1'b1, 1'b0, "R3 clear auto");
    cmd(1'b1, 1'b0, 1, 8'd1); chk(1, 1'b0, 1'b1, "R8 setup");
    cmd(1'b0, 1'b1, 1, 8'd0); chk(1, 1'b0, 1'b1, "R8 clear power holds");
    cmd(1'b1, 1'b1, 1, 8'd2); chk(1, 1'b1, 1'b0, "R8 set power auto");
  endtask

  task automatic t_isolation();
    en = '1;
    cmd(1'b1, 1'b0, 2, 8'd1); chk(2, 1'b0, 1'b1, "R9 target");
    chk(3, 1'b1, 1'b0, "R9 neighbour 3"); chk(1, 1'b1, 1'b0, "R9 neighbour 1");
    cmd(1'b1, 1'b0, 3, 8'd3); chk(3, 1'b0, 1'b0, "R9 port 3 off");
    chk(2, 1'b0, 1'b1, "R9 port 2 held");
    @(negedge clk);
    cv = 1'b1; cs = 1'b0; cf = 1'b0; cp = 2'd2; csel = 8'd0;
    #1 chk(2, 1'b0, 1'b1, "R9 not before edge");
    @(negedge clk); cv = 1'b0;
    chk(2, 1'b1, 1'b0, "R9 after edge");
    chk(3, 1'b0, 1'b0, "R9 port 3 untouched");
    oc = '1; settle();
    for (int p = 0; p < 3; p++) chk(p, 1'b0, 1'b1, "R10 all oc");
    chk(3, 1'b0, 1'b0, "R10 manual off");
    oc = '0; en = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_auto();
    t_manual();
    t_reserved();
    t_to_auto();
    t_isolation();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule